// File: doc/BRIEF.md
# Multichannel DAC SPI Register Core

This block is the digital control side of an eight-channel, 16-bit voltage-output DAC. An SPI slave, running in mode 0, receives a 16-bit header and then one or more data bytes. The header holds a read/write flag and a 15-bit register address. The block decodes each byte into a register read or write and steps the address by one after every data byte. One transaction can therefore fill both bytes of a channel code, or the codes of several channels in a row.

Each channel's code is double-buffered. A host write lands in the channel's input register only. The code reaches the active register, and so the converter output, when a load event occurs. A load event is either a self-clearing trigger bit written over SPI or a rising edge on a dedicated load pin. When a load event occurs, every channel transfers at once.

The block also holds the following state:
- a 2-bit operating-mode field per channel, packed four channels to a register;
- an output-range-doubling bit;
- an internal-reference-select bit;
- a software reset command.

The block samples all SPI and load pins with the system clock, so the whole core lives in one clock domain.

Top module: `dac_regcore`

## Requirements
- R1: An SPI transaction (mode 0, MSB first, framed by `spi_cs_n` low) has three parts. First comes a 16-bit header: bit 15 is 1 for a read and 0 for a write, and bits 14:0 are the start address. Data bytes follow, and the address increments by one after each byte. In a read, byte k returns the register at start+k.
- R2: Channel c's 16-bit input code is held at byte addresses 0xEB+2c (bits 15:8) and 0xEC+2c (bits 7:0). A write there leaves `dac_code` unchanged until a load event occurs.
- R3: Writing a byte with bit 7 set to address 0xE5 copies every channel's input code to its active code on `dac_code`, where channel c occupies bits 16c+15:16c. Address 0xE5 reads back as 0x00.
- R4: A rising edge on `ldac_in` copies every channel's input code to its active code.
- R5: Address 0x20 holds the modes of channels 0–3 and 0x21 those of channels 4–7, each at bits 2(c mod 4)+1:2(c mod 4). Each mode appears on `pd_mode` bits 2c+1:2c. The encoding is 0 normal, 1 off with 1 kΩ to ground, 2 off with 7.7 kΩ, and 3 off with 32 kΩ. Both mode registers read back as written.
- R6: A channel whose mode is not normal still takes its new active code on a load event, and its mode output is unchanged by the load.
- R7: Bit 2 of address 0x2A drives `range_x2` and bit 0 of address 0x3C drives `int_ref`. Each register reads back only that bit, with every other bit 0.
- R8: Writing a byte with bits 7 and 0 both set to address 0x00 returns all input codes, active codes, modes, `range_x2` and `int_ref` to 0.
- R9: Reads of unmapped addresses return 0x00, and writes to them change nothing. Examples are 0x50 and 0xFB, the first address above the channel codes. A write to 0x00 without both bits 7 and 0 set also changes nothing.
- R10: A read of a channel-code address returns the buffered input code, not the active code.
- R11: After `rst`, all active codes, modes, `range_x2` and `int_ref` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock (idle low) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| ldac_in | input | 1 | Hardware load strobe; rising edge transfers all codes |
| dac_code | output | 128 | Active codes, channel c at bits 16c+15:16c |
| pd_mode | output | 16 | Operating mode per channel, channel c at bits 2c+1:2c |
| range_x2 | output | 1 | Doubled output range selected |
| int_ref | output | 1 | Internal reference selected |

## Verification
The assertions assume that `spi_sclk` has a half period of several system clocks. Under that assumption two completed bytes never fall within one cycle, and each write strobe stands alone. They also assume that `ldac_in` pulses last longer than the two-stage synchronizer, so that each pulse gives exactly one rising edge. The bench drives the serial clock with a half period of six system clocks. It holds chip select low for a half period before the first edge and after the last edge. It widens every load pulse to several system clocks, so the stimulus stays inside those assumptions.

// File: rtl/dac_pkg.sv
package dac_pkg;
    localparam int ADDR_W      = 15;
    localparam int BYTE_W      = 8;
    localparam int CODE_W      = 16;
    localparam int MODE_W      = 2;
    localparam int CH_PER_MODE = 4;

    localparam logic [ADDR_W-1:0] A_CFG   = 15'h0000;
    localparam logic [ADDR_W-1:0] A_MODE0 = 15'h0020;
    localparam logic [ADDR_W-1:0] A_RANGE = 15'h002A;
    localparam logic [ADDR_W-1:0] A_REF   = 15'h003C;
    localparam logic [ADDR_W-1:0] A_TRIG  = 15'h00E5;
    localparam logic [ADDR_W-1:0] A_CODE0 = 15'h00EB;

    localparam int RST_HI_BIT = 7;
    localparam int RST_LO_BIT = 0;
    localparam int TRIG_BIT   = 7;
    localparam int RANGE_BIT  = 2;
    localparam int REF_BIT    = 0;

    typedef enum logic [2:0] {
        K_NONE, K_CFG, K_MODE, K_RANGE, K_REF, K_TRIG, K_CODE
    } reg_kind_e;

    typedef enum logic [1:0] {
        M_NORMAL, M_OFF_1K, M_OFF_7K7, M_OFF_32K
    } op_mode_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
        logic       lo;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(logic [ADDR_W-1:0] a, int num_ch);
        reg_dec_t d;
        logic [ADDR_W-1:0] off;
        d.kind = K_NONE;
        d.idx  = '0;
        d.lo   = 1'b0;
        off    = a - A_CODE0;
        if (a == A_CFG)
            d.kind = K_CFG;
        else if (a == A_RANGE)
            d.kind = K_RANGE;
        else if (a == A_REF)
            d.kind = K_REF;
        else if (a == A_TRIG)
            d.kind = K_TRIG;
        else if (a >= A_MODE0 && a < A_MODE0 + ADDR_W'(num_ch / CH_PER_MODE)) begin
            d.kind = K_MODE;
            d.idx  = 8'(a - A_MODE0);
        end else if (a >= A_CODE0 && off < ADDR_W'(2 * num_ch)) begin
            d.kind = K_CODE;
            d.idx  = 8'(off >> 1);
            d.lo   = off[0];
        end
        return d;
    endfunction
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= {STAGES{RST_VAL}};
        else     stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dac_spi_slave.sv
module dac_spi_slave
    import dac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              miso
);
    typedef enum logic {PH_HDR, PH_DATA} phase_e;

    localparam int HDR_BITS = ADDR_W + 1;
    localparam int CNT_W    = $clog2(HDR_BITS);

    phase_e            phase;
    logic              sclk_q;
    logic [ADDR_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              rd_mode;
    logic [BYTE_W-1:0] tx;
    logic              load_tx;
    logic              rise, fall;

    assign rise = sclk_s & ~sclk_q;
    assign fall = ~sclk_s & sclk_q;
    assign miso = tx[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_HDR;
            sclk_q  <= 1'b0;
            shreg   <= '0;
            cnt     <= '0;
            rd_mode <= 1'b0;
            tx      <= '0;
            load_tx <= 1'b0;
            rd_addr <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            sclk_q  <= sclk_s;
            wr_en   <= 1'b0;
            load_tx <= 1'b0;
            if (cs_n_s) begin
                phase <= PH_HDR;
                cnt   <= '0;
            end else begin
                if (rise) begin
                    shreg <= {shreg[ADDR_W-2:0], mosi_s};
                    if (phase == PH_HDR) begin
                        if (cnt == CNT_W'(HDR_BITS - 1)) begin
                            phase   <= PH_DATA;
                            cnt     <= '0;
                            rd_mode <= shreg[ADDR_W-1];
                            rd_addr <= {shreg[ADDR_W-2:0], mosi_s};
                            load_tx <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end else begin
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            cnt     <= '0;
                            rd_addr <= rd_addr + 1'b1;
                            load_tx <= 1'b1;
                            if (!rd_mode) begin
                                wr_en   <= 1'b1;
                                wr_addr <= rd_addr;
                                wr_data <= {shreg[BYTE_W-2:0], mosi_s};
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                if (fall && phase == PH_DATA && cnt != '0)
                    tx <= {tx[BYTE_W-2:0], 1'b0};
            end
            if (load_tx) tx <= rd_data;
        end
    end

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);  // R1
    AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> rd_addr == wr_addr + 1'b1);  // R1
endmodule

// File: rtl/dac_regfile.sv
module dac_regfile
    import dac_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [BYTE_W-1:0]        rd_data,
    input  logic                     ldac_s,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH*MODE_W-1:0] pd_mode,
    output logic                     range_x2,
    output logic                     int_ref
);
    logic [NUM_CH*CODE_W-1:0] in_flat;
    reg_dec_t wdec, rdec;
    logic trig_q, ldac_q, ldac_rise, load, soft_rst, clr;

    assign wdec      = decode_addr(wr_addr, NUM_CH);
    assign rdec      = decode_addr(rd_addr, NUM_CH);
    assign soft_rst  = wr_en && wdec.kind == K_CFG
                       && wr_data[RST_HI_BIT] && wr_data[RST_LO_BIT];
    assign clr       = rst | soft_rst;
    assign ldac_rise = ldac_s & ~ldac_q;
    assign load      = trig_q | ldac_rise;

    always_ff @(posedge clk) begin
        if (rst) ldac_q <= 1'b0;
        else     ldac_q <= ldac_s;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            trig_q   <= 1'b0;
            range_x2 <= 1'b0;
            int_ref  <= 1'b0;
        end else begin
            trig_q <= wr_en && wdec.kind == K_TRIG && wr_data[TRIG_BIT];
            if (wr_en && wdec.kind == K_RANGE) range_x2 <= wr_data[RANGE_BIT];
            if (wr_en && wdec.kind == K_REF)   int_ref  <= wr_data[REF_BIT];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [CODE_W-1:0] in_q, act_q;
        op_mode_e          mode_q;
        logic              hit_code, hit_mode;

        assign hit_code = wr_en && wdec.kind == K_CODE && wdec.idx == 8'(c);
        assign hit_mode = wr_en && wdec.kind == K_MODE && wdec.idx == 8'(c / CH_PER_MODE);

        always_ff @(posedge clk) begin
            if (clr)
                in_q <= '0;
            else if (hit_code) begin
                if (wdec.lo) in_q[BYTE_W-1:0]      <= wr_data;
                else         in_q[CODE_W-1:BYTE_W] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (clr)       act_q <= '0;
            else if (load) act_q <= in_q;
        end

        always_ff @(posedge clk) begin
            if (clr)
                mode_q <= M_NORMAL;
            else if (hit_mode)
                mode_q <= op_mode_e'(wr_data[MODE_W*(c % CH_PER_MODE) +: MODE_W]);
        end

        assign in_flat[c*CODE_W +: CODE_W]  = in_q;
        assign dac_code[c*CODE_W +: CODE_W] = act_q;
        assign pd_mode[c*MODE_W +: MODE_W]  = mode_q;
    end

    always_comb begin
        rd_data = '0;
        case (rdec.kind)
            K_MODE:  rd_data = pd_mode[int'(rdec.idx)*BYTE_W +: BYTE_W];
            K_RANGE: rd_data[RANGE_BIT] = range_x2;
            K_REF:   rd_data[REF_BIT]   = int_ref;
            K_TRIG:  rd_data[TRIG_BIT]  = trig_q;
            K_CODE:  rd_data = rdec.lo ? in_flat[int'(rdec.idx)*CODE_W +: BYTE_W]
                                       : in_flat[int'(rdec.idx)*CODE_W + BYTE_W +: BYTE_W];
            default: rd_data = '0;
        endcase
    end

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!load && !soft_rst) |=> $stable(dac_code));  // R2
    AST_TRIG_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        trig_q |=> !trig_q);  // R3
    AST_TRIG_COPY: assert property (@(posedge clk) disable iff (rst)
        (trig_q && !soft_rst) |=> dac_code == $past(in_flat));  // R3
    AST_PIN_COPY: assert property (@(posedge clk) disable iff (rst)
        (ldac_rise && !soft_rst) |=> dac_code == $past(in_flat));  // R4
    AST_LOAD_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (load && !wr_en) |=> $stable(pd_mode));  // R6
    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (dac_code == '0 && pd_mode == '0 && !range_x2 && !int_ref));  // R8
    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdec.kind == K_NONE) |=> ($stable(in_flat) && $stable(pd_mode)
                                            && $stable(range_x2) && $stable(int_ref)));  // R9
endmodule

// File: rtl/dac_regcore.sv
module dac_regcore
    import dac_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     spi_sclk,
    input  logic                     spi_cs_n,
    input  logic                     spi_mosi,
    output logic                     spi_miso,
    input  logic                     ldac_in,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH*MODE_W-1:0] pd_mode,
    output logic                     range_x2,
    output logic                     int_ref
);
    logic sclk_s, cs_n_s, mosi_s, ldac_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    dac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst(rst), .d(spi_sclk), .q(sclk_s));
    dac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst(rst), .d(spi_cs_n), .q(cs_n_s));
    dac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst(rst), .d(spi_mosi), .q(mosi_s));
    dac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ldac (
        .clk(clk), .rst(rst), .d(ldac_in), .q(ldac_s));

    dac_spi_slave u_spi (
        .clk(clk), .rst(rst),
        .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .miso(spi_miso));

    dac_regfile #(.NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ldac_s(ldac_s),
        .dac_code(dac_code), .pd_mode(pd_mode),
        .range_x2(range_x2), .int_ref(int_ref));
endmodule

// File: tb/test_dac_regcore.sv
module test_dac_regcore;
    localparam int NCH  = 8;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, ldac = 1'b0;
    logic miso, range_x2, int_ref;
    logic [NCH*16-1:0] dac_code;
    logic [NCH*2-1:0]  pd_mode;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [15:0] exp_in  [NCH];
    logic [15:0] exp_act [NCH];

    always #2 clk = ~clk;

    dac_regcore i_dac_regcore (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .ldac_in(ldac),
        .dac_code(dac_code), .pd_mode(pd_mode),
        .range_x2(range_x2), .int_ref(int_ref));

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [127:0] exp_codes();
        logic [127:0] v = '0;
        for (int c = 0; c < NCH; c++) v[c*16 +: 16] = exp_act[c];
        return v;
    endfunction

    task automatic do_load();
        for (int c = 0; c < NCH; c++) exp_act[c] = exp_in[c];
    endtask

    task automatic spi_txn(input logic rd, input logic [14:0] a, input int n,
                           input logic [31:0] wd, output logic [31:0] rdat);
        logic [15:0] hdr;
        logic [7:0]  b;
        hdr  = {rd, a};
        rdat = '0;
        cs_n = 1'b0;
        cyc(HALF);
        for (int i = 15; i >= 0; i--) begin
            mosi = hdr[i]; cyc(HALF); sclk = 1'b1; cyc(HALF); sclk = 1'b0;
        end
        for (int k = 0; k < n; k++) begin
            for (int i = 7; i >= 0; i--) begin
                mosi = wd[24 - 8*k + i]; cyc(HALF);
                b[i] = miso; sclk = 1'b1; cyc(HALF); sclk = 1'b0;
            end
            rdat[24 - 8*k +: 8] = b;
        end
        cyc(HALF);
        cs_n = 1'b1;
        cyc(10);
    endtask

    task automatic wr1(input logic [14:0] a, input logic [7:0] d);
        logic [31:0] r;
        spi_txn(1'b0, a, 1, {d, 24'h0}, r);
    endtask

    task automatic rd1(input logic [14:0] a, output logic [7:0] d);
        logic [31:0] r;
        spi_txn(1'b1, a, 1, 32'h0, r);
        d = r[31:24];
    endtask

    task automatic wr_code(input int ch, input logic [15:0] v);
        logic [31:0] r;
        spi_txn(1'b0, 15'(16'hEB + 2*ch), 2, {v, 16'h0}, r);
        exp_in[ch] = v;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R11 dac_code after reset", dac_code, '0);
        chk("R11 pd_mode after reset", 128'(pd_mode), '0);
        chk("R11 range/ref after reset", 128'({range_x2, int_ref}), '0);
        rd1(15'h20, d);
        chk("R11 mode reg after reset", 128'(d), '0);
    endtask

    task automatic t_buffered();
        logic [31:0] r;
        wr_code(0, 16'h1234);
        wr_code(7, 16'hBEEF);
        chk("R2 outputs unchanged before load", dac_code, exp_codes());
        spi_txn(1'b0, 15'hED, 4, 32'h5A6B_7C8D, r);
        exp_in[1] = 16'h5A6B; exp_in[2] = 16'h7C8D;
        spi_txn(1'b1, 15'hEB, 4, 32'h0, r);
        chk("R1 R10 burst read ch0-ch1", 128'(r), 128'(32'h1234_5A6B));
        spi_txn(1'b1, 15'hF9, 2, 32'h0, r);
        chk("R10 ch7 readback", 128'(r[31:16]), 128'(16'hBEEF));
        chk("R2 outputs still unchanged", dac_code, exp_codes());
    endtask

    task automatic t_swtrig();
        logic [7:0] d;
        wr1(15'hE5, 8'h80);
        do_load();
        chk("R3 software load copies all", dac_code, exp_codes());
        rd1(15'hE5, d);
        chk("R3 trigger reads 0", 128'(d), '0);
    endtask

    task automatic t_ldac();
        wr_code(3, 16'h0F0F);
        chk("R2 ch3 held before pin load", dac_code, exp_codes());
        ldac = 1'b1; cyc(6); ldac = 1'b0; cyc(6);
        do_load();
        chk("R4 pin load copies", dac_code, exp_codes());
    endtask

    task automatic t_mode();
        logic [7:0] d;
        wr1(15'h20, 8'hE4);
        wr1(15'h21, 8'h1B);
        chk("R5 pd_mode fields", 128'(pd_mode), 128'(16'h1BE4));
        rd1(15'h21, d);
        chk("R5 mode reg readback", 128'(d), 128'(8'h1B));
    endtask

    task automatic t_pd_update();
        wr_code(3, 16'hA5A5);
        wr1(15'hE5, 8'h80);
        do_load();
        chk("R6 powered-down ch3 code updates", dac_code, exp_codes());
        chk("R6 mode kept after load", 128'(pd_mode), 128'(16'h1BE4));
    endtask

    task automatic t_range();
        logic [7:0] d;
        wr1(15'h2A, 8'h04);
        wr1(15'h3C, 8'hFF);
        chk("R7 range and ref set", 128'({range_x2, int_ref}), 128'(2'b11));
        rd1(15'h3C, d);
        chk("R7 ref readback single bit", 128'(d), 128'(8'h01));
        wr1(15'h2A, 8'hFB);
        chk("R7 range cleared by bit2=0", 128'({range_x2, int_ref}), 128'(2'b01));
        rd1(15'h2A, d);
        chk("R7 range readback", 128'(d), '0);
        wr1(15'h2A, 8'h04);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        wr1(15'h50, 8'hFF);
        rd1(15'h50, d);
        chk("R9 unmapped read 0", 128'(d), '0);
        wr1(15'hFB, 8'hFF);
        rd1(15'hFB, d);
        chk("R9 above codes read 0", 128'(d), '0);
        wr1(15'h00, 8'h80);
        wr1(15'h00, 8'h01);
        chk("R9 partial reset no effect modes", 128'(pd_mode), 128'(16'h1BE4));
        chk("R9 partial reset no effect codes", dac_code, exp_codes());
        chk("R9 partial reset no effect bits", 128'({range_x2, int_ref}), 128'(2'b11));
    endtask

    task automatic t_softrst();
        logic [7:0] d;
        wr1(15'h00, 8'h81);
        for (int c = 0; c < NCH; c++) begin exp_in[c] = '0; exp_act[c] = '0; end
        chk("R8 codes cleared", dac_code, '0);
        chk("R8 modes cleared", 128'(pd_mode), '0);
        chk("R8 range/ref cleared", 128'({range_x2, int_ref}), '0);
        rd1(15'hEB, d);
        chk("R8 input code cleared", 128'(d), '0);
        wr1(15'hE5, 8'h80);
        chk("R8 load after reset gives 0", dac_code, '0);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin exp_in[c] = '0; exp_act[c] = '0; end
        cyc(5);
        rst = 1'b0;
        cyc(5);
        t_reset();
        t_buffered();
        t_swtrig();
        t_ldac();
        t_mode();
        t_pd_update();
        t_range();
        t_unmapped();
        t_softrst();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule